// File: doc/BRIEF.md
# Shared-Control Part-2 Assembler with Identity-Masked CRC

This block builds the 29-bit word that feeds the channel coder for the second half of a downlink shared control message. A single start strobe captures every control field. These are the code-set and modulation bits that belong to the first half, and the block-size, process, redundancy-version and new-data fields that belong to the second half, along with a 16-bit terminal identity. The block then runs a 16-bit CRC over all 21 control bits, one bit per clock.

The CRC covers both halves of the message, but only the second-half bits appear in the output word. The 16 parity bits are XORed with the terminal identity and placed after them. A receiver that holds a different identity therefore sees a CRC failure and drops the message. A single-cycle done pulse marks the clock in which a new word becomes valid. The word then holds its value until the next word completes. While a computation is running, further start strobes are ignored.

Top module: `ctl2_mux_crc`

## Requirements
- R1: During and directly after a synchronous active-high reset, `busy_o` and `done_o` are 0 and `word_o` is all zeros.
- R2: A start strobe sampled while idle is accepted at that clock edge. `busy_o` is 1 from the following cycle. `done_o` is high for exactly one cycle, which begins at the 21st rising edge after the accepting edge. `busy_o` falls in that same cycle.
- R3: A start strobe sampled while `busy_o` is 1 is ignored, and so are any field changes made while busy. The result and its latency are those of the accepted start.
- R4: Output bits y1..y13 sit at `word_o[28:16]`, with y1 at bit 28. In order they are the block size (6 bits), the process number (3), the redundancy version (3) and the new-data bit (1). Each field's highest-index input bit goes first.
- R5: The CRC uses generator x^16+x^12+x^5+1 with a zero start state. Bits are fed one at a time in this order: the code set (bit 6 first), the modulation bit, then the 13 second-half bits in R4 order.
- R6: y14..y29 sit at `word_o[15:0]`. `word_o[15-k]` = CRC parity bit of degree 15-k XOR `term_id_i[15-k]`, so the highest-degree parity bit is masked by `term_id_i[15]`.
- R7: `word_o` changes only in a cycle where `done_o` is 1, and otherwise keeps its value.
- R8: The first-half fields (code set, modulation) change only `word_o[15:0]`. They never appear in `word_o[28:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled when idle |
| cset_i | input | 7 | Code-set field (first half) |
| mod_i | input | 1 | Modulation bit (first half) |
| tbs_i | input | 6 | Transport-block size field |
| hap_i | input | 3 | Retransmission process number |
| rv_i | input | 3 | Redundancy version field |
| nd_i | input | 1 | New-data bit |
| term_id_i | input | 16 | Terminal identity used as CRC mask |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: word_o just updated |
| word_o | output | 29 | Assembled word, y1 at bit 28 |

## Verification
A wrong internal state shows at the ports as soon as the next word completes, 21 cycles after acceptance. A stale or re-captured second-half field appears directly in `word_o[28:16]`. A wrong CRC state, a skipped shift, a wrong bit order or a wrong mask polarity corrupts `word_o[15:0]` in a way that depends on the data. For that reason the cases include an all-zero message, a lone final bit, all ones, and messages that differ only in their first-half fields. A counter that is off by one shows up in the very first transaction as a done pulse on the wrong cycle. Mis-handled busy gating shows up as a word taken from the second, ignored field set.

// File: rtl/ctl2_pkg.sv
package ctl2_pkg;

    // Field widths of the shared control message
    localparam int CSET_W = 7;
    localparam int MOD_W  = 1;
    localparam int TBS_W  = 6;
    localparam int HAP_W  = 3;
    localparam int RV_W   = 3;
    localparam int ND_W   = 1;
    localparam int CRC_W  = 16;

    // Generator x^16 + x^12 + x^5 + 1, leading term implied
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

endpackage

// File: rtl/ctl2_field_pack.sv
module ctl2_field_pack #(
    parameter int CSET_W = 7,
    parameter int MOD_W  = 1,
    parameter int TBS_W  = 6,
    parameter int HAP_W  = 3,
    parameter int RV_W   = 3,
    parameter int ND_W   = 1,
    localparam int P1_W  = CSET_W + MOD_W,
    localparam int P2_W  = TBS_W + HAP_W + RV_W + ND_W
) (
    input  logic [CSET_W-1:0] cset_i,
    input  logic [MOD_W-1:0]  mod_i,
    input  logic [TBS_W-1:0]  tbs_i,
    input  logic [HAP_W-1:0]  hap_i,
    input  logic [RV_W-1:0]   rv_i,
    input  logic [ND_W-1:0]   nd_i,
    output logic [P1_W-1:0]   part1_o,
    output logic [P2_W-1:0]   part2_o
);

    // Leftmost bit is transmitted first in both halves
    always_comb begin
        part1_o = {cset_i, mod_i};
        part2_o = {tbs_i, hap_i, rv_i, nd_i};
    end

endmodule

// File: rtl/ctl2_crc_step.sv
module ctl2_crc_step #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

endmodule

// File: rtl/ctl2_id_mask.sv
module ctl2_id_mask #(
    parameter int W = 16
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] id_i,
    output logic [W-1:0] masked_o
);

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign masked_o[k] = crc_i[k] ^ id_i[k];
    end

endmodule

// File: rtl/ctl2_mux_crc.sv
module ctl2_mux_crc
    import ctl2_pkg::*;
#(
    parameter int                CSET_WP = CSET_W,
    parameter int                MOD_WP  = MOD_W,
    parameter int                TBS_WP  = TBS_W,
    parameter int                HAP_WP  = HAP_W,
    parameter int                RV_WP   = RV_W,
    parameter int                ND_WP   = ND_W,
    parameter int                CRC_WP  = CRC_W,
    parameter logic [CRC_WP-1:0] POLY    = CRC_POLY,
    localparam int P1_W  = CSET_WP + MOD_WP,
    localparam int P2_W  = TBS_WP + HAP_WP + RV_WP + ND_WP,
    localparam int MSG_W = P1_W + P2_W,
    localparam int OUT_W = P2_W + CRC_WP,
    localparam int CNT_W = $clog2(MSG_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CSET_WP-1:0] cset_i,
    input  logic [MOD_WP-1:0]  mod_i,
    input  logic [TBS_WP-1:0]  tbs_i,
    input  logic [HAP_WP-1:0]  hap_i,
    input  logic [RV_WP-1:0]   rv_i,
    input  logic [ND_WP-1:0]   nd_i,
    input  logic [CRC_WP-1:0]  term_id_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [OUT_W-1:0]   word_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MSG_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [MSG_W-1:0]  msg;
        logic [P2_W-1:0]   p2;
        logic [CRC_WP-1:0] id;
        logic [CRC_WP-1:0] crc;
        logic [OUT_W-1:0]  word;
    } state_t;

    state_t s_d, s_q;

    logic [P1_W-1:0]   part1;
    logic [P2_W-1:0]   part2;
    logic [CRC_WP-1:0] crc_nx;
    logic [CRC_WP-1:0] crc_masked;

    ctl2_field_pack #(
        .CSET_W(CSET_WP), .MOD_W(MOD_WP), .TBS_W(TBS_WP),
        .HAP_W(HAP_WP), .RV_W(RV_WP), .ND_W(ND_WP)
    ) u_pack (
        .cset_i (cset_i),
        .mod_i  (mod_i),
        .tbs_i  (tbs_i),
        .hap_i  (hap_i),
        .rv_i   (rv_i),
        .nd_i   (nd_i),
        .part1_o(part1),
        .part2_o(part2)
    );

    // One message bit per cycle, MSB of the shift register first
    ctl2_crc_step #(.W(CRC_WP), .POLY(POLY)) u_step (
        .crc_i(s_q.crc),
        .bit_i(s_q.msg[MSG_W-1]),
        .crc_o(crc_nx)
    );

    ctl2_id_mask #(.W(CRC_WP)) u_mask (
        .crc_i   (crc_nx),
        .id_i    (s_q.id),
        .masked_o(crc_masked)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.msg  = {part1, part2};
                s_d.p2   = part2;
                s_d.id   = term_id_i;
                s_d.crc  = '0;
            end
        end else begin
            s_d.crc = crc_nx;
            s_d.msg = {s_q.msg[MSG_W-2:0], 1'b0};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_BIT) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.word = {s_q.p2, crc_masked};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign word_o = s_q.word;

endmodule

// File: rtl/ctl2_mux_crc_chk.sv
module ctl2_mux_crc_chk #(
    parameter int P2_W  = 13,
    parameter int MSG_W = 21,
    parameter int OUT_W = 29,
    localparam int CW   = $clog2(MSG_W + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [5:0]       tbs_i,
    input logic [2:0]       hap_i,
    input logic [2:0]       rv_i,
    input logic             nd_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OUT_W-1:0] word_o
);

    logic [CW-1:0]   cyc;
    logic [P2_W-1:0] cap_p2;

    // Independent window counter and field capture for the checks below
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= '0;
            cap_p2 <= '0;
        end else if (start_i && !busy_o) begin
            cyc    <= '0;
            cap_p2 <= {tbs_i, hap_i, rv_i, nd_i};
        end else if (busy_o) begin
            cyc <= cyc + 1'b1;
        end
    end

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o |=> busy_o);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (int'(cyc) == MSG_W));

    assert_part2_fields_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (word_o[OUT_W-1 -: P2_W] == cap_p2));

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(word_o));

endmodule

bind ctl2_mux_crc ctl2_mux_crc_chk #(
    .P2_W(13), .MSG_W(21), .OUT_W(29)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .tbs_i  (tbs_i),
    .hap_i  (hap_i),
    .rv_i   (rv_i),
    .nd_i   (nd_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .word_o (word_o)
);

// File: tb/ctl2_mux_crc_test.sv
`timescale 1ns/1ps
module ctl2_mux_crc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [6:0]  cset_i = '0;
    logic        mod_i = 1'b0;
    logic [5:0]  tbs_i = '0;
    logic [2:0]  hap_i = '0;
    logic [2:0]  rv_i = '0;
    logic        nd_i = 1'b0;
    logic [15:0] term_id_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [28:0] word_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ctl2_mux_crc uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cset_i(cset_i), .mod_i(mod_i), .tbs_i(tbs_i), .hap_i(hap_i),
        .rv_i(rv_i), .nd_i(nd_i), .term_id_i(term_id_i),
        .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
    );

    function automatic logic [15:0] ref_crc(input logic [20:0] m);
        logic [15:0] c = '0;
        for (int i = 20; i >= 0; i--) begin
            logic fb = c[15] ^ m[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [28:0] ref_word(input logic [6:0] cs, input logic md,
        input logic [5:0] tb, input logic [2:0] hp, input logic [2:0] rv,
        input logic nd, input logic [15:0] id);
        logic [12:0] p2 = {tb, hp, rv, nd};
        return {p2, ref_crc({cs, md, p2}) ^ id};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 word", 32'(word_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 word after release", 32'(word_o), 0);
    endtask

    // Runs one transaction; optionally strobes start with other fields mid-run (R3)
    task automatic run_msg(input string tag, input logic [6:0] cs, input logic md,
        input logic [5:0] tb, input logic [2:0] hp, input logic [2:0] rv,
        input logic nd, input logic [15:0] id, input bit spam,
        output logic [28:0] got);
        logic [28:0] exp = ref_word(cs, md, tb, hp, rv, nd, id);
        bit early = 0;
        @(negedge clk);
        cset_i = cs; mod_i = md; tbs_i = tb; hap_i = hp; rv_i = rv;
        nd_i = nd; term_id_i = id; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " R2 busy after accept"}, 32'(busy_o), 1);
        for (int i = 1; i <= 21; i++) begin
            @(negedge clk);
            if (i < 21 && done_o) early = 1;
            if (spam && i == 5) begin
                start_i = 1'b1; cset_i = ~cs; tbs_i = ~tb; nd_i = ~nd;
                term_id_i = ~id; hap_i = ~hp;
            end
            if (spam && i == 9) start_i = 1'b0;
        end
        check({tag, " R2 no early done"}, 32'(early), 0);
        check({tag, " R2 done at cycle 21"}, 32'(done_o), 1);
        check({tag, " R2 busy cleared"}, 32'(busy_o), 0);
        check({tag, " R4/R5/R6 word"}, 32'(word_o), 32'(exp));
        got = word_o;
        @(negedge clk);
        check({tag, " R2 done one cycle"}, 32'(done_o), 0);
        check({tag, " R7 word held"}, 32'(word_o), 32'(exp));
    endtask

    task automatic test_zero;
        logic [28:0] w;
        run_msg("zero", '0, 0, '0, '0, '0, 0, 16'h0000, 0, w);
        check("R5 zero message", 32'(w), 0);
    endtask

    task automatic test_last_bit;
        logic [28:0] w;
        run_msg("lastbit", '0, 0, '0, '0, '0, 1, 16'h0000, 0, w);
        check("R5 single last bit gives generator", 32'(w[15:0]), 32'h1021);
        check("R4 nd at y13", 32'(w[28:16]), 32'h0001);
    endtask

    task automatic test_identity;
        logic [28:0] w;
        run_msg("idonly", '0, 0, '0, '0, '0, 0, 16'h8001, 0, w);
        check("R6 mask order", 32'(w), 32'h0000_8001);
    endtask

    task automatic test_part1;
        logic [28:0] wa, wb;
        run_msg("p1a", 7'h40, 0, 6'h2A, 3'h5, 3'h2, 1, 16'h1234, 0, wa);
        run_msg("p1b", 7'h00, 1, 6'h2A, 3'h5, 3'h2, 1, 16'h1234, 0, wb);
        check("R8 part-1 absent from y1..y13", 32'(wa[28:16]), 32'(wb[28:16]));
        check("R8 part-1 in crc", 32'(wa[15:0] != wb[15:0]), 1);
    endtask

    task automatic test_fields;
        logic [28:0] w;
        run_msg("ones", 7'h7F, 1, 6'h3F, 3'h7, 3'h7, 1, 16'hFFFF, 0, w);
        run_msg("mixed", 7'h15, 0, 6'h21, 3'h3, 3'h4, 0, 16'hA5C3, 0, w);
        check("R4 field order", 32'(w[28:16]), 32'({6'h21, 3'h3, 3'h4, 1'b0}));
    endtask

    task automatic test_busy_ignore;
        logic [28:0] w;
        run_msg("ignore R3", 7'h33, 1, 6'h0C, 3'h1, 3'h6, 1, 16'h5A5A, 1, w);
        run_msg("after ignore R3", 7'h01, 0, 6'h10, 3'h2, 3'h1, 0, 16'h0F0F, 0, w);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_zero();
        test_last_bit();
        test_identity();
        test_part1();
        test_fields();
        test_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule